// File: doc/BRIEF.md
# Integrating ADC Conversion Sequencer

This block times the integration windows of two light-measurement channels that run side by side. An internal oscillator supplies a one-cycle tick. Each channel delivers a pulse input, and that input is sampled on every tick. While a window is open, the sequencer counts the pulses of each channel in its own accumulator. The count rate is limited to one count per two ticks. The count carries a fixed offset of two and saturates at the top of the data width.

When a window closes, both results move together into the output data registers, a one-cycle done strobe is raised, and the next window opens on the following tick. The window length comes from a two-bit field in a small timing register, as a multiple of a base unit of oscillator periods. One value of that field hands the window to the host instead: a manual bit starts the window and stops it. A power-enable input halts the whole sequencer. A gain bit is stored and passed out, and it does not touch the counting.

Top module: `integ_adc_seq`

## Requirements
- R1: The timing register resets to 8'h02. Its layout is bits [1:0] for the window select, bit 3 for the manual bit and bit 4 for gain. `tim_q` reads back a write with the other bits forced to 0, and `gain_hi` follows bit 4 without changing any count.
- R2: Window select 00, 01 and 10 gives a window of 11, 81 and 322 times `UNIT_CYC` oscillator ticks. With the window running freely, successive done strobes are exactly that many ticks apart.
- R3: A channel's pulse input is sampled only on tick cycles. A sampled pulse is counted only if that channel counted nothing on the previous tick of the same window.
- R4: The transferred value is the number of counted pulses minus 2, with a floor of 0. With `UNIT_CYC`=4 and a pulse on every tick, select 00 gives 20 and select 01 gives 160.
- R5: The transferred value saturates at 2^`CNT_W`-1.
- R6: Both data registers load at the same clock edge. `done` is high for the one cycle after that edge, and the data outputs change at no other time.
- R7: In the timed selects the next window begins on the tick after a window ends, so no tick is lost between windows.
- R8: Select 11 is manual mode. A write with the manual bit at 1 starts a window. A write with it at 0 ends the window, transfers the results and raises `done`. No further window starts until the manual bit is written to 1 again. In the other selects the manual bit has no effect.
- R9: While `pwr_en` is low, `busy` is low and no transfer happens. The accumulators are cleared and the data registers keep their last values. When power returns, a timed select starts a fresh window.
- R10: A write that changes the window select abandons the open window without a transfer. The new window is counted from the tick after that write.
- R11: With the default `UNIT_CYC` of 918, a pulse on every tick gives full scale values of 5047 for select 00 and 37177 for select 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator tick |
| pwr_en | input | 1 | Sequencer enable; low powers the sequencer down |
| tim_we | input | 1 | Timing register write strobe |
| tim_wdata | input | 8 | Timing register write data |
| ch0_pulse | input | 1 | Channel 0 pulse, sampled on ticks |
| ch1_pulse | input | 1 | Channel 1 pulse, sampled on ticks |
| tim_q | output | 8 | Timing register readback |
| gain_hi | output | 1 | Stored gain bit |
| busy | output | 1 | A window is open |
| done | output | 1 | One-cycle transfer strobe |
| data0 | output | CNT_W | Channel 0 result |
| data1 | output | CNT_W | Channel 1 result |

## Verification
The main function is tried with four pulse patterns: never, every tick, every second tick and every fourth tick. These are spread across all three timed selects and several tick rates. A pulse on every tick and a pulse on every second tick give the same count, which shows that the rate limit works. The every-fourth pattern separates the offset from the limit. The silent pattern shows the floor at zero, and the longest select shows saturation. Directed runs then cover a manual start and stop, power loss in the middle of a window, a change of select in the middle of a window, a gain write that includes the manual bit, and the two full-scale values at the default unit.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    typedef struct packed {
        logic       gain;
        logic       manual;
        logic [1:0] integ;
    } tcfg_t;

    localparam logic [1:0] INTEG_MAN = 2'b11;
    localparam logic [7:0] TIM_RST   = 8'h02;

    function automatic int unsigned win_mult(input logic [1:0] sel);
        case (sel)
            2'b00:   win_mult = 11;
            2'b01:   win_mult = 81;
            default: win_mult = 322;
        endcase
    endfunction

    function automatic tcfg_t tim_unpack(input logic [7:0] d);
        tcfg_t c;
        c.gain   = d[4];
        c.manual = d[3];
        c.integ  = d[1:0];
        return c;
    endfunction

    function automatic logic [7:0] tim_pack(input tcfg_t c);
        return {3'b000, c.gain, c.manual, 1'b0, c.integ};
    endfunction

endpackage

// File: rtl/iseq_tim_reg.sv
module iseq_tim_reg
    import iseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [7:0]  wdata,
    output tcfg_t       cfg_q,
    output tcfg_t       cfg_nx,
    output logic        restart,
    output logic        man_set,
    output logic        man_clr
);
    logic nx_is_man;

    always_comb begin
        cfg_nx    = tim_unpack(wdata);
        nx_is_man = (cfg_nx.integ == INTEG_MAN);
        restart   = we && (cfg_nx.integ != cfg_q.integ);
        man_set   = we && !restart && nx_is_man && cfg_nx.manual;
        man_clr   = we && !restart && nx_is_man && !cfg_nx.manual;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= tim_unpack(TIM_RST);
        else if (we)
            cfg_q <= cfg_nx;
    end
endmodule

// File: rtl/iseq_win_ctrl.sv
module iseq_win_ctrl
    import iseq_pkg::*;
#(
    parameter int UNIT_CYC = 918
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_en,
    input  logic       osc_tick,
    input  logic [1:0] integ,
    input  logic [1:0] nx_integ,
    input  logic       nx_manual,
    input  logic       restart,
    input  logic       man_set,
    input  logic       man_clr,
    output logic       running,
    output logic       cnt_en,
    output logic       xfer
);
    localparam int WIN_MAX = 322 * UNIT_CYC;
    localparam int WIN_W   = $clog2(WIN_MAX + 1);

    logic [WIN_W-1:0] tick_cnt;
    logic [WIN_W-1:0] win_len;
    logic             is_auto;
    logic             end_auto;
    logic             end_man;

    always_comb begin
        win_len  = WIN_W'(win_mult(integ) * UNIT_CYC);
        is_auto  = (integ != INTEG_MAN);
        end_auto = running && is_auto && osc_tick && (tick_cnt == win_len - WIN_W'(1));
        end_man  = running && !is_auto && man_clr;
        xfer     = pwr_en && !restart && (end_auto || end_man);
        cnt_en   = pwr_en && running && osc_tick && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            running  <= 1'b0;
            tick_cnt <= '0;
        end else if (restart) begin
            running  <= (nx_integ != INTEG_MAN) || nx_manual;
            tick_cnt <= '0;
        end else if (is_auto) begin
            running <= 1'b1;
            if (end_auto)
                tick_cnt <= '0;
            else if (running && osc_tick)
                tick_cnt <= tick_cnt + WIN_W'(1);
        end else begin
            tick_cnt <= '0;
            if (man_set)
                running <= 1'b1;
            else if (man_clr)
                running <= 1'b0;
        end
    end
endmodule

// File: rtl/iseq_chan.sv
module iseq_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cnt_en,
    input  logic             pulse,
    output logic [CNT_W-1:0] res
);
    localparam int             RAW_W   = CNT_W + 1;
    localparam logic [RAW_W-1:0] RAW_MAX = {1'b1, {(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [RAW_W-1:0] OFFSET  = RAW_W'(2);

    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] raw_fold;
    logic             cool;
    logic             accept;

    always_comb begin
        accept   = cnt_en && pulse && !cool;
        raw_fold = (accept && (raw != RAW_MAX)) ? raw + RAW_W'(1) : raw;
        if (raw_fold < OFFSET)
            res = '0;
        else
            res = CNT_W'(raw_fold - OFFSET);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            raw  <= '0;
            cool <= 1'b0;
        end else begin
            raw <= raw_fold;
            if (cnt_en)
                cool <= accept;
        end
    end
endmodule

// File: rtl/integ_adc_seq.sv
module integ_adc_seq
    import iseq_pkg::*;
#(
    parameter int UNIT_CYC = 918,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             pwr_en,
    input  logic             tim_we,
    input  logic [7:0]       tim_wdata,
    input  logic             ch0_pulse,
    input  logic             ch1_pulse,
    output logic [7:0]       tim_q,
    output logic             gain_hi,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] data0,
    output logic [CNT_W-1:0] data1
);
    localparam int NCH = 2;

    tcfg_t            cfg_q;
    tcfg_t            cfg_nx;
    logic             restart;
    logic             man_set;
    logic             man_clr;
    logic             running;
    logic             cnt_en;
    logic             xfer;
    logic             acc_clr;
    logic [NCH-1:0]   pulse_v;
    logic [CNT_W-1:0] res_v  [NCH];
    logic [CNT_W-1:0] data_r [NCH];

    iseq_tim_reg u_tim (
        .clk     (clk),
        .rst     (rst),
        .we      (tim_we),
        .wdata   (tim_wdata),
        .cfg_q   (cfg_q),
        .cfg_nx  (cfg_nx),
        .restart (restart),
        .man_set (man_set),
        .man_clr (man_clr)
    );

    iseq_win_ctrl #(.UNIT_CYC(UNIT_CYC)) u_win (
        .clk       (clk),
        .rst       (rst),
        .pwr_en    (pwr_en),
        .osc_tick  (osc_tick),
        .integ     (cfg_q.integ),
        .nx_integ  (cfg_nx.integ),
        .nx_manual (cfg_nx.manual),
        .restart   (restart),
        .man_set   (man_set),
        .man_clr   (man_clr),
        .running   (running),
        .cnt_en    (cnt_en),
        .xfer      (xfer)
    );

    assign acc_clr = !pwr_en || restart || xfer || !running;
    assign pulse_v = {ch1_pulse, ch0_pulse};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        iseq_chan #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .clear  (acc_clr),
            .cnt_en (cnt_en),
            .pulse  (pulse_v[i]),
            .res    (res_v[i])
        );

        always_ff @(posedge clk) begin
            if (rst)
                data_r[i] <= '0;
            else if (xfer)
                data_r[i] <= res_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else
            done <= xfer;
    end

    assign tim_q   = tim_pack(cfg_q);
    assign gain_hi = cfg_q.gain;
    assign busy    = running;
    assign data0   = data_r[0];
    assign data1   = data_r[1];
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk #(
    parameter int UNIT_CYC = 918,
    parameter int CNT_W    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_en,
    input logic             tim_we,
    input logic             busy,
    input logic             done,
    input logic [1:0]       integ,
    input logic [CNT_W-1:0] data0,
    input logic [CNT_W-1:0] data1
);
    localparam longint FS00 = (11 * UNIT_CYC + 1) / 2 - 2;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(data0) && $stable(data1)));

    // R9
    pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> (!busy && !done));

    // R7
    auto_run_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && busy && integ != 2'b11 && !tim_we) |=> busy);

    // R8
    man_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (integ == 2'b11 && !busy && !tim_we) |=> !busy);

    // R4
    full_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (done && integ == 2'b00) |-> (longint'(data0) <= FS00 && longint'(data1) <= FS00));
endmodule

bind integ_adc_seq iseq_chk #(.UNIT_CYC(UNIT_CYC), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pwr_en (pwr_en),
    .tim_we (tim_we),
    .busy   (busy),
    .done   (done),
    .integ  (cfg_q.integ),
    .data0  (data0),
    .data1  (data1)
);

// File: tb/tb_integ_adc_seq.sv
module tb_integ_adc_seq;

    typedef struct packed {
        logic [1:0]  integ;
        logic [1:0]  tdiv;
        logic [1:0]  p0;
        logic [1:0]  p1;
        logic [15:0] e0;
        logic [15:0] e1;
        logic [15:0] win;
    } vec_t;

    // patterns: 0 never, 1 every tick, 2 every 4th tick, 3 every 2nd tick
    localparam vec_t VEC [6] = '{
        '{2'b00, 2'd1, 2'd1, 2'd0, 16'd20,  16'd0,   16'd44},
        '{2'b00, 2'd2, 2'd3, 2'd2, 16'd20,  16'd9,   16'd44},
        '{2'b01, 2'd1, 2'd2, 2'd1, 16'd79,  16'd160, 16'd324},
        '{2'b01, 2'd3, 2'd0, 2'd3, 16'd0,   16'd160, 16'd324},
        '{2'b10, 2'd1, 2'd1, 2'd2, 16'd255, 16'd255, 16'd1288},
        '{2'b10, 2'd2, 2'd2, 2'd0, 16'd255, 16'd0,   16'd1288}
    };

    logic clk = 0;
    logic rst = 1;
    logic osc_tick = 0;
    logic ch0 = 0, ch1 = 0;
    logic s_pwr = 0, s_we = 0, f_pwr = 0, f_we = 0;
    logic [7:0] s_wd = 0, f_wd = 0;
    logic [7:0] s_tq, f_tq;
    logic s_gain, f_gain, s_busy, f_busy, s_done, f_done;
    logic [7:0]  s_d0, s_d1;
    logic [15:0] f_d0, f_d1;

    int checks = 0, fails = 0, cyc = 0;
    int tdiv = 1, dcnt = 0, tk = 0, burst = 0;
    bit tick_on = 0;
    logic [1:0] pat0 = 0, pat1 = 0;

    always #4 clk = ~clk;

    integ_adc_seq #(.UNIT_CYC(4), .CNT_W(8)) dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .pwr_en(s_pwr),
        .tim_we(s_we), .tim_wdata(s_wd), .ch0_pulse(ch0), .ch1_pulse(ch1),
        .tim_q(s_tq), .gain_hi(s_gain), .busy(s_busy), .done(s_done),
        .data0(s_d0), .data1(s_d1));

    integ_adc_seq dut_full (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .pwr_en(f_pwr),
        .tim_we(f_we), .tim_wdata(f_wd), .ch0_pulse(ch0), .ch1_pulse(ch1),
        .tim_q(f_tq), .gain_hi(f_gain), .busy(f_busy), .done(f_done),
        .data0(f_d0), .data1(f_d1));

    function automatic logic patf(input logic [1:0] p, input int t);
        case (p)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return (t % 4) == 0;
            default: return (t % 2) == 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (burst > 0) begin
            osc_tick = 1; burst = burst - 1;
        end else if (tick_on) begin
            if (dcnt >= tdiv - 1) begin osc_tick = 1; dcnt = 0; end
            else begin osc_tick = 0; dcnt = dcnt + 1; end
        end else begin
            osc_tick = 0;
        end
        if (osc_tick) begin
            ch0 = patf(pat0, tk); ch1 = patf(pat1, tk); tk = tk + 1;
        end else begin
            ch0 = 0; ch1 = 0;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks = checks + 1; fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit full, input logic [7:0] d);
        @(posedge clk); #1;
        if (full) begin f_we = 1; f_wd = d; end
        else begin s_we = 1; s_wd = d; end
        @(posedge clk); #1;
        s_we = 0; f_we = 0;
    endtask

    task automatic wait_done(input bit full, input int lim, output int n, output bit got);
        n = 0; got = 0;
        while (n < lim && !got) begin
            @(posedge clk); #1;
            n = n + 1;
            if (full ? f_done : s_done) got = 1;
        end
    endtask

    initial begin
        int n;
        bit got;
        cycles(5);
        rst = 0;
        cycles(1);
        // reset state
        chk("R1 reset timing value", s_tq, 8'h02);
        chk("R1 reset gain", s_gain, 0);
        chk("R9 reset busy", s_busy, 0);
        chk("R6 reset done", s_done, 0);
        chk("R6 reset data0", s_d0, 0);
        chk("R6 reset data1", s_d1, 0);

        // vector walk
        for (int v = 0; v < 6; v++) begin
            int per;
            s_pwr = 0; tick_on = 0;
            cycles(3);
            wr(0, {6'b0, VEC[v].integ});
            tdiv = int'(VEC[v].tdiv); pat0 = VEC[v].p0; pat1 = VEC[v].p1;
            dcnt = 0; tick_on = 1; s_pwr = 1;
            per = int'(VEC[v].win) * tdiv;
            wait_done(0, per + 20, n, got);
            chk("R6 first window done", got, 1);
            chk("R3 R4 R5 channel 0 result", s_d0, VEC[v].e0);
            chk("R3 R4 R5 channel 1 result", s_d1, VEC[v].e1);
            wait_done(0, per + 20, n, got);
            chk("R2 R7 window spacing", n, per);
            chk("R6 repeat channel 0", s_d0, VEC[v].e0);
            chk("R6 repeat channel 1", s_d1, VEC[v].e1);
        end

        // gain write with manual bit set in a timed select
        s_pwr = 0; tick_on = 0;
        cycles(2);
        wr(0, 8'h00);
        tdiv = 1; pat0 = 1; pat1 = 0; dcnt = 0; tick_on = 1; s_pwr = 1;
        wait_done(0, 80, n, got);
        wr(0, 8'h18);
        chk("R1 readback", s_tq, 8'h18);
        chk("R1 gain out", s_gain, 1);
        chk("R8 manual bit ignored busy", s_busy, 1);
        wait_done(0, 80, n, got);
        chk("R8 manual bit ignored spacing", n, 42);
        chk("R1 gain has no effect on count", s_d0, 20);
        wr(0, 8'hE4);
        chk("R1 reserved bits read zero", s_tq, 8'h00);

        // power loss mid-window
        wait_done(0, 80, n, got);
        cycles(10);
        s_pwr = 0; pat0 = 2;
        cycles(1);
        chk("R9 busy low when powered down", s_busy, 0);
        wait_done(0, 100, n, got);
        chk("R9 no transfer while down", got, 0);
        chk("R9 data held", s_d0, 20);
        s_pwr = 1;
        wait_done(0, 60, n, got);
        chk("R9 fresh window after power up", s_d0, 9);
        chk("R9 channel 1 after power up", s_d1, 0);

        // select change mid-window
        pat0 = 1;
        wr(0, 8'h01);
        wait_done(0, 100, n, got);
        chk("R10 no transfer in long window yet", got, 0);
        wr(0, 8'h00);
        wait_done(0, 60, n, got);
        chk("R10 new window counted from write", n, 44);
        chk("R10 no partial result", s_d0, 20);

        // manual mode
        tick_on = 0; pat0 = 1; pat1 = 0;
        cycles(3);
        wr(0, 8'h0B);
        chk("R8 manual start busy", s_busy, 1);
        burst = 30;
        wait_done(0, 40, n, got);
        chk("R8 no done while manual window open", got, 0);
        wr(0, 8'h03);
        chk("R8 manual stop done", s_done, 1);
        chk("R8 manual stop channel 0", s_d0, 13);
        chk("R8 manual stop channel 1", s_d1, 0);
        tick_on = 1;
        wait_done(0, 300, n, got);
        chk("R8 no restart after stop", got, 0);
        chk("R8 idle after stop", s_busy, 0);
        wr(0, 8'h0B);
        chk("R8 restart on manual set", s_busy, 1);

        // full scale at the default unit
        tick_on = 0;
        cycles(2);
        wr(1, 8'h00);
        tdiv = 1; pat0 = 1; pat1 = 1; dcnt = 0; tick_on = 1; f_pwr = 1;
        wait_done(1, 10200, n, got);
        chk("R11 full scale select 00 ch0", f_d0, 5047);
        chk("R11 full scale select 00 ch1", f_d1, 5047);
        wr(1, 8'h01);
        wait_done(1, 74400, n, got);
        chk("R2 R10 select 01 window", n, 74358);
        chk("R11 full scale select 01 ch0", f_d0, 37177);
        chk("R11 full scale select 01 ch1", f_d1, 37177);

        summary();
        $finish;
    end
endmodule